// File: doc/BRIEF.md
# I2C Controller Status Word

This block holds the 16-bit status word of an I2C controller. A separate bit/byte engine drives it with single-cycle event strobes: Start, Stop, address match (with its direction bit), general-call match, second-byte match of a 10-bit address, end of an acknowledge slot (with the sampled level), received byte ready, master transmit start, transmit byte taken for shifting, and bus collision. Software drives a small register interface. It can write the transmit buffer, read the receive buffer and clear the three flags that only software may clear.

Each flag has its own set and clear events. Some flags clear on their own at Stop. Some flags stay set until software clears them. Others follow the engine in both directions. Transmit writes are checked against the engine's busy state and against the transmit-buffer-full flag. Received bytes are checked against the receive-buffer-full flag. A rejected write or an overrun raises a sticky error flag and leaves the buffer unchanged.

Top module: `i2c_status_unit`

## Requirements
- R1: The status word places its flags at these bit positions: 15 acknowledge status (1 = NACK), 14 master transmit in progress, 10 bus collision, 9 general call seen, 8 10-bit address matched, 7 write collision, 6 receive overflow, 5 data/address (1 = data), 4 Stop seen, 3 Start seen, 2 read/write direction of the last matched address, 1 receive buffer full, 0 transmit buffer full.
- R2: After reset every status bit is 0, and bits 13 to 11 always read 0.
- R3: At the end of an acknowledge slot, bit 15 takes the sampled level. Bit 14 goes to 1 on master transmit start and back to 0 at the end of the acknowledge slot.
- R4: Bit 10 is set by a bus collision. Only the software collision-clear strobe clears it, and a Stop does not.
- R5: Bits 9 and 8 are set by a general-call match and by a 10-bit second-byte match. A Stop clears both, and the Stop takes priority when it arrives in the same cycle as a set.
- R6: A Start sets bit 3 and clears bit 4. A Stop sets bit 4 and clears bit 3.
- R7: An address match clears bit 5 and loads bit 2 with the direction input. An accepted transmit write, or a received byte flagged as data, sets bit 5.
- R8: A transmit write while the engine is idle and bit 0 is 0 is accepted. It stores the byte on the transmit data output and sets bit 0. The engine's load strobe clears bit 0.
- R9: A transmit write while the engine is busy or bit 0 is 1 is discarded. The transmit data and bit 0 stay unchanged, and bit 7 is set. Bit 7 clears only through the software write-collision clear.
- R10: A received byte is moved to the receive data output and sets bit 1. A software read clears bit 1. A received byte that arrives in the same cycle as a read is accepted, and bit 1 stays 1.
- R11: A received byte that arrives while bit 1 is 1 and no read is in progress sets bit 6 and leaves the receive data unchanged. Bit 6 clears only through the software overflow clear.
- R12: For bits 10, 7 and 6, a set event wins over a software clear in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| ev_start | input | 1 | Start detected |
| ev_stop | input | 1 | Stop detected |
| ev_addr_match | input | 1 | Device address matched |
| ev_addr_rw | input | 1 | Direction bit of the matched address |
| ev_gcall | input | 1 | General-call address matched |
| ev_addr10 | input | 1 | Second 10-bit address byte matched |
| ev_ack_done | input | 1 | Acknowledge slot finished |
| ev_ack_val | input | 1 | Sampled acknowledge level, 1 = NACK |
| ev_rx_byte | input | 1 | Received byte ready in the shift register |
| ev_rx_is_data | input | 1 | The received byte is slave data |
| ev_rx_data | input | DATA_W | Received byte |
| ev_tx_start | input | 1 | Master transmit started |
| ev_tx_load | input | 1 | Engine took the transmit byte |
| ev_collision | input | 1 | Bus collision during a master operation |
| eng_busy | input | 1 | Engine busy, transmit writes rejected |
| sw_tx_we | input | 1 | Software transmit-buffer write |
| sw_tx_data | input | DATA_W | Software transmit byte |
| sw_rx_re | input | 1 | Software receive-buffer read |
| sw_clr_bcl | input | 1 | Clear bus collision flag |
| sw_clr_wcol | input | 1 | Clear write collision flag |
| sw_clr_ovf | input | 1 | Clear receive overflow flag |
| status | output | 16 | Status word |
| rx_data | output | DATA_W | Receive buffer |
| tx_data | output | DATA_W | Transmit buffer, to the engine |

## Verification
The bench targets same-cycle collisions. A clear strobe that arrives together with a set event must leave the flag set. A design with the priority reversed would lose a collision or overflow report. A receive that arrives during a read must be accepted without reporting an overrun. A real overrun must keep the old byte, and a design that overwrote it would return the wrong data. Writes rejected because of busy or a full buffer must leave the transmit byte untouched. A Stop must drop the general-call and 10-bit flags but keep the collision flag, and a design that shared one clear path would fail one of these checks.

// File: rtl/i2c_stat_pkg.sv
package i2c_stat_pkg;
   localparam int unsigned STAT_W    = 16;
   localparam int unsigned BIT_ACK   = 15;
   localparam int unsigned BIT_TRS   = 14;
   localparam int unsigned BIT_BCL   = 10;
   localparam int unsigned BIT_GC    = 9;
   localparam int unsigned BIT_A10   = 8;
   localparam int unsigned BIT_WCOL  = 7;
   localparam int unsigned BIT_OVF   = 6;
   localparam int unsigned BIT_DA    = 5;
   localparam int unsigned BIT_STOP  = 4;
   localparam int unsigned BIT_START = 3;
   localparam int unsigned BIT_RW    = 2;
   localparam int unsigned BIT_RBF   = 1;
   localparam int unsigned BIT_TBF   = 0;

   typedef enum logic {PRIO_CLEAR = 1'b0, PRIO_SET = 1'b1} flag_prio_e;
endpackage

// File: rtl/i2c_stat_flag.sv
module i2c_stat_flag
   import i2c_stat_pkg::*;
#(
   parameter flag_prio_e PRIO = PRIO_SET
) (
   input  logic clk,
   input  logic rst_n,
   input  logic set_i,
   input  logic clr_i,
   output logic q_o
);
   logic nxt;

   generate
      if (PRIO == PRIO_SET) begin : g_set_wins
         always_comb nxt = set_i ? 1'b1 : (clr_i ? 1'b0 : q_o);
      end else begin : g_clr_wins
         always_comb nxt = clr_i ? 1'b0 : (set_i ? 1'b1 : q_o);
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) q_o <= 1'b0;
      else        q_o <= nxt;
   end
endmodule

// File: rtl/i2c_stat_bufs.sv
module i2c_stat_bufs
   import i2c_stat_pkg::*;
#(
   parameter int unsigned DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              eng_busy,
   input  logic              sw_tx_we,
   input  logic [DATA_W-1:0] sw_tx_data,
   input  logic              sw_rx_re,
   input  logic              ev_rx_byte,
   input  logic [DATA_W-1:0] ev_rx_data,
   input  logic              ev_tx_load,
   input  logic              clr_wcol,
   input  logic              clr_ovf,
   output logic [DATA_W-1:0] tx_data,
   output logic [DATA_W-1:0] rx_data,
   output logic              tbf,
   output logic              rbf,
   output logic              wcol,
   output logic              ovf,
   output logic              tx_accept
);
   generate
      if (DATA_W < 1 || DATA_W > 32) begin : g_bad_width
         $error("i2c_stat_bufs: DATA_W out of range");
      end
   endgenerate

   logic tx_reject, rx_take, rx_over;

   assign tx_reject = sw_tx_we & (eng_busy | tbf);
   assign tx_accept = sw_tx_we & ~tx_reject;
   assign rx_take   = ev_rx_byte & (~rbf | sw_rx_re);
   assign rx_over   = ev_rx_byte & rbf & ~sw_rx_re;

   i2c_stat_flag #(.PRIO(PRIO_SET)) u_tbf  (.clk(clk), .rst_n(rst_n), .set_i(tx_accept), .clr_i(ev_tx_load), .q_o(tbf));
   i2c_stat_flag #(.PRIO(PRIO_SET)) u_rbf  (.clk(clk), .rst_n(rst_n), .set_i(rx_take),   .clr_i(sw_rx_re),   .q_o(rbf));
   i2c_stat_flag #(.PRIO(PRIO_SET)) u_wcol (.clk(clk), .rst_n(rst_n), .set_i(tx_reject), .clr_i(clr_wcol),   .q_o(wcol));
   i2c_stat_flag #(.PRIO(PRIO_SET)) u_ovf  (.clk(clk), .rst_n(rst_n), .set_i(rx_over),   .clr_i(clr_ovf),    .q_o(ovf));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         tx_data <= '0;
         rx_data <= '0;
      end else begin
         if (tx_accept) tx_data <= sw_tx_data;
         if (rx_take)   rx_data <= ev_rx_data;
      end
   end

   AST_WCOL_RAISED:   assert property (@(posedge clk) disable iff (!rst_n) (sw_tx_we && (eng_busy || tbf)) |=> wcol); // R9
   AST_TX_HELD:       assert property (@(posedge clk) disable iff (!rst_n) (sw_tx_we && (eng_busy || tbf)) |=> $stable(tx_data)); // R9
   AST_NO_OVERFLOW:   assert property (@(posedge clk) disable iff (!rst_n) (ev_rx_byte && rbf && !sw_rx_re) |=> (ovf && $stable(rx_data))); // R11
   AST_RBF_DRAINED:   assert property (@(posedge clk) disable iff (!rst_n) (sw_rx_re && !ev_rx_byte) |=> !rbf); // R10
   AST_WCOL_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n) (clr_wcol && tx_reject) |=> wcol); // R12
endmodule

// File: rtl/i2c_status_unit.sv
module i2c_status_unit
   import i2c_stat_pkg::*;
#(
   parameter int unsigned DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ev_start,
   input  logic              ev_stop,
   input  logic              ev_addr_match,
   input  logic              ev_addr_rw,
   input  logic              ev_gcall,
   input  logic              ev_addr10,
   input  logic              ev_ack_done,
   input  logic              ev_ack_val,
   input  logic              ev_rx_byte,
   input  logic              ev_rx_is_data,
   input  logic [DATA_W-1:0] ev_rx_data,
   input  logic              ev_tx_start,
   input  logic              ev_tx_load,
   input  logic              ev_collision,
   input  logic              eng_busy,
   input  logic              sw_tx_we,
   input  logic [DATA_W-1:0] sw_tx_data,
   input  logic              sw_rx_re,
   input  logic              sw_clr_bcl,
   input  logic              sw_clr_wcol,
   input  logic              sw_clr_ovf,
   output logic [15:0]       status,
   output logic [DATA_W-1:0] rx_data,
   output logic [DATA_W-1:0] tx_data
);
   generate
      if (STAT_W != 16) begin : g_bad_stat
         $error("i2c_status_unit: status word must be 16 bits");
      end
   endgenerate

   // flag slots: 0 trs, 1 bcl, 2 gc, 3 a10, 4 start, 5 stop, 6 d/a
   localparam int unsigned NFLAG = 7;
   localparam logic [NFLAG-1:0] SET_WINS = 7'b0100011;
   localparam int F_TRS = 0, F_BCL = 1, F_GC = 2, F_A10 = 3, F_S = 4, F_P = 5, F_DA = 6;

   logic [NFLAG-1:0] fset, fclr, fq;
   logic tbf, rbf, wcol, ovf, tx_accept;
   logic ack_q, rw_q;

   i2c_stat_bufs #(.DATA_W(DATA_W)) u_bufs (
      .clk(clk), .rst_n(rst_n), .eng_busy(eng_busy),
      .sw_tx_we(sw_tx_we), .sw_tx_data(sw_tx_data), .sw_rx_re(sw_rx_re),
      .ev_rx_byte(ev_rx_byte), .ev_rx_data(ev_rx_data), .ev_tx_load(ev_tx_load),
      .clr_wcol(sw_clr_wcol), .clr_ovf(sw_clr_ovf),
      .tx_data(tx_data), .rx_data(rx_data), .tbf(tbf), .rbf(rbf),
      .wcol(wcol), .ovf(ovf), .tx_accept(tx_accept)
   );

   always_comb begin
      fset        = '0;
      fclr        = '0;
      fset[F_TRS] = ev_tx_start;   fclr[F_TRS] = ev_ack_done;
      fset[F_BCL] = ev_collision;  fclr[F_BCL] = sw_clr_bcl;
      fset[F_GC]  = ev_gcall;      fclr[F_GC]  = ev_stop;
      fset[F_A10] = ev_addr10;     fclr[F_A10] = ev_stop;
      fset[F_S]   = ev_start;      fclr[F_S]   = ev_stop;
      fset[F_P]   = ev_stop;       fclr[F_P]   = ev_start;
      fset[F_DA]  = tx_accept | (ev_rx_byte & ev_rx_is_data);
      fclr[F_DA]  = ev_addr_match;
   end

   genvar gi;
   generate
      for (gi = 0; gi < NFLAG; gi++) begin : g_flag
         i2c_stat_flag #(.PRIO(SET_WINS[gi] ? PRIO_SET : PRIO_CLEAR)) u_flag (
            .clk(clk), .rst_n(rst_n), .set_i(fset[gi]), .clr_i(fclr[gi]), .q_o(fq[gi])
         );
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ack_q <= 1'b0;
         rw_q  <= 1'b0;
      end else begin
         if (ev_ack_done)   ack_q <= ev_ack_val;
         if (ev_addr_match) rw_q  <= ev_addr_rw;
      end
   end

   always_comb begin
      status            = '0;
      status[BIT_ACK]   = ack_q;
      status[BIT_TRS]   = fq[F_TRS];
      status[BIT_BCL]   = fq[F_BCL];
      status[BIT_GC]    = fq[F_GC];
      status[BIT_A10]   = fq[F_A10];
      status[BIT_WCOL]  = wcol;
      status[BIT_OVF]   = ovf;
      status[BIT_DA]    = fq[F_DA];
      status[BIT_STOP]  = fq[F_P];
      status[BIT_START] = fq[F_S];
      status[BIT_RW]    = rw_q;
      status[BIT_RBF]   = rbf;
      status[BIT_TBF]   = tbf;
   end

   AST_ACK_FOLLOWS:   assert property (@(posedge clk) disable iff (!rst_n) ev_ack_done |=> (status[BIT_ACK] == $past(ev_ack_val))); // R3
   AST_TRS_ENDS:      assert property (@(posedge clk) disable iff (!rst_n) (ev_ack_done && !ev_tx_start) |=> !status[BIT_TRS]); // R3
   AST_BCL_STICKY:    assert property (@(posedge clk) disable iff (!rst_n) (status[BIT_BCL] && !sw_clr_bcl) |=> status[BIT_BCL]); // R4
   AST_STOP_DROPS:    assert property (@(posedge clk) disable iff (!rst_n) ev_stop |=> (!status[BIT_GC] && !status[BIT_A10])); // R5
   AST_SP_EXCLUSIVE:  assert property (@(posedge clk) disable iff (!rst_n) !(status[BIT_START] && status[BIT_STOP])); // R6
   AST_DA_ON_MATCH:   assert property (@(posedge clk) disable iff (!rst_n) ev_addr_match |=> (!status[BIT_DA] && status[BIT_RW] == $past(ev_addr_rw))); // R7
   AST_BCL_SET_WINS:  assert property (@(posedge clk) disable iff (!rst_n) (ev_collision && sw_clr_bcl) |=> status[BIT_BCL]); // R12
endmodule

// File: tb/tb_i2c_status_unit.sv
module tb_i2c_status_unit;
   localparam int DW = 8;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic ev_start, ev_stop, ev_addr_match, ev_addr_rw, ev_gcall, ev_addr10;
   logic ev_ack_done, ev_ack_val, ev_rx_byte, ev_rx_is_data, ev_tx_start;
   logic ev_tx_load, ev_collision, eng_busy, sw_tx_we, sw_rx_re;
   logic sw_clr_bcl, sw_clr_wcol, sw_clr_ovf;
   logic [DW-1:0] ev_rx_data, sw_tx_data, rx_data, tx_data;
   logic [15:0] status;

   int checks = 0;
   int errors = 0;
   int cyc = 0;
   bit finished = 0;

   always #2.5 clk = ~clk;

   i2c_status_unit #(.DATA_W(DW)) dut (
      .clk(clk), .rst_n(rst_n), .ev_start(ev_start), .ev_stop(ev_stop),
      .ev_addr_match(ev_addr_match), .ev_addr_rw(ev_addr_rw), .ev_gcall(ev_gcall),
      .ev_addr10(ev_addr10), .ev_ack_done(ev_ack_done), .ev_ack_val(ev_ack_val),
      .ev_rx_byte(ev_rx_byte), .ev_rx_is_data(ev_rx_is_data), .ev_rx_data(ev_rx_data),
      .ev_tx_start(ev_tx_start), .ev_tx_load(ev_tx_load), .ev_collision(ev_collision),
      .eng_busy(eng_busy), .sw_tx_we(sw_tx_we), .sw_tx_data(sw_tx_data),
      .sw_rx_re(sw_rx_re), .sw_clr_bcl(sw_clr_bcl), .sw_clr_wcol(sw_clr_wcol),
      .sw_clr_ovf(sw_clr_ovf), .status(status), .rx_data(rx_data), .tx_data(tx_data)
   );

   task automatic idle();
      ev_start = 0; ev_stop = 0; ev_addr_match = 0; ev_addr_rw = 0; ev_gcall = 0;
      ev_addr10 = 0; ev_ack_done = 0; ev_ack_val = 0; ev_rx_byte = 0; ev_rx_is_data = 0;
      ev_tx_start = 0; ev_tx_load = 0; ev_collision = 0; sw_tx_we = 0; sw_rx_re = 0;
      sw_clr_bcl = 0; sw_clr_wcol = 0; sw_clr_ovf = 0;
   endtask

   // inputs are set at a falling edge; one rising edge later the result is sampled
   task automatic step();
      @(negedge clk);
      idle();
   endtask

   task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic t_reset();
      chk("R2 reset word", {16'h0, status}, 32'h0);
      chk("R2 reset rx", {24'h0, rx_data}, 32'h0);
   endtask

   task automatic t_start_stop();
      ev_start = 1; step();
      chk("R6 start sets bit3", {16'h0, status}, 32'h0008);
      ev_stop = 1; step();
      chk("R6 stop sets bit4 clears bit3", {16'h0, status}, 32'h0010);
   endtask

   task automatic t_slave_addr();
      ev_start = 1; step();
      ev_addr_match = 1; ev_addr_rw = 1; ev_gcall = 1; step();
      chk("R1 R7 R5 address/gcall", {16'h0, status}, 32'h020C);
      ev_addr10 = 1; step();
      chk("R5 10-bit flag", {31'h0, status[8]}, 32'h1);
      ev_rx_byte = 1; ev_rx_is_data = 1; ev_rx_data = 8'hA5; step();
      chk("R10 R7 data byte word", {16'h0, status}, 32'h032E);
      chk("R10 rx data", {24'h0, rx_data}, 32'hA5);
      ev_stop = 1; step();
      chk("R5 R6 stop clears gc/a10", {16'h0, status}, 32'h0036);
      sw_rx_re = 1; step();
      chk("R10 read clears bit1", {31'h0, status[1]}, 32'h0);
      ev_addr10 = 1; ev_stop = 1; step();
      chk("R5 stop beats set", {31'h0, status[8]}, 32'h0);
      ev_addr_match = 1; ev_addr_rw = 0; step();
      chk("R7 match clears d/a, rw=0", {30'h0, status[5], status[2]}, 32'h0);
      chk("R2 reserved bits", {29'h0, status[13:11]}, 32'h0);
   endtask

   task automatic t_overflow();
      ev_rx_byte = 1; ev_rx_data = 8'h11; step();
      ev_rx_byte = 1; ev_rx_data = 8'h22; step();
      chk("R11 overflow flag", {31'h0, status[6]}, 32'h1);
      chk("R11 old byte kept", {24'h0, rx_data}, 32'h11);
      ev_rx_byte = 1; ev_rx_data = 8'h33; sw_rx_re = 1; step();
      chk("R10 read+rx same cycle data", {24'h0, rx_data}, 32'h33);
      chk("R10 read+rx same cycle bit1", {31'h0, status[1]}, 32'h1);
      sw_clr_ovf = 1; step();
      chk("R11 sw clear", {31'h0, status[6]}, 32'h0);
      sw_clr_ovf = 1; ev_rx_byte = 1; ev_rx_data = 8'h44; step();
      chk("R12 overflow set beats clear", {31'h0, status[6]}, 32'h1);
      chk("R11 byte kept after second overrun", {24'h0, rx_data}, 32'h33);
      sw_clr_ovf = 1; sw_rx_re = 1; step();
      chk("R10 R11 drained", {30'h0, status[6], status[1]}, 32'h0);
   endtask

   task automatic t_transmit();
      eng_busy = 0;
      sw_tx_we = 1; sw_tx_data = 8'h5A; step();
      chk("R8 accepted write bit0", {31'h0, status[0]}, 32'h1);
      chk("R8 tx data", {24'h0, tx_data}, 32'h5A);
      chk("R7 write sets d/a", {31'h0, status[5]}, 32'h1);
      sw_tx_we = 1; sw_tx_data = 8'hC3; step();
      chk("R9 full write collides", {31'h0, status[7]}, 32'h1);
      chk("R9 full write discarded", {24'h0, tx_data}, 32'h5A);
      ev_tx_load = 1; step();
      chk("R8 load clears bit0", {31'h0, status[0]}, 32'h0);
      sw_clr_wcol = 1; step();
      chk("R9 sw clear", {31'h0, status[7]}, 32'h0);
      eng_busy = 1; sw_tx_we = 1; sw_tx_data = 8'h77; step();
      chk("R9 busy write collides", {31'h0, status[7]}, 32'h1);
      chk("R9 busy write no bit0", {31'h0, status[0]}, 32'h0);
      chk("R9 busy write data kept", {24'h0, tx_data}, 32'h5A);
      sw_tx_we = 1; sw_clr_wcol = 1; step();
      chk("R12 collision set beats clear", {31'h0, status[7]}, 32'h1);
      ev_stop = 1; step();
      chk("R9 stop leaves bit7", {31'h0, status[7]}, 32'h1);
      sw_clr_wcol = 1; step();
      eng_busy = 0;
      chk("R9 cleared", {31'h0, status[7]}, 32'h0);
   endtask

   task automatic t_master();
      ev_tx_start = 1; step();
      chk("R3 transmit in progress", {31'h0, status[14]}, 32'h1);
      ev_ack_done = 1; ev_ack_val = 1; step();
      chk("R3 ack end: trs=0 nack=1", {30'h0, status[15], status[14]}, 32'h2);
      ev_ack_done = 1; ev_ack_val = 0; step();
      chk("R3 ack seen", {31'h0, status[15]}, 32'h0);
      ev_collision = 1; step();
      chk("R4 collision sets bit10", {31'h0, status[10]}, 32'h1);
      ev_stop = 1; step();
      chk("R4 stop keeps bit10", {31'h0, status[10]}, 32'h1);
      sw_clr_bcl = 1; step();
      chk("R4 sw clear", {31'h0, status[10]}, 32'h0);
      ev_collision = 1; sw_clr_bcl = 1; step();
      chk("R12 bcl set beats clear", {31'h0, status[10]}, 32'h1);
   endtask

   always @(posedge clk) begin
      cyc++;
      if (cyc > 20000 && !finished) begin
         finished = 1;
         errors++;
         $display("FAIL watchdog actual=%0d expected=<20000", cyc);
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      idle();
      eng_busy = 0; ev_rx_data = '0; sw_tx_data = '0;
      repeat (3) @(negedge clk);
      t_reset();
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_start_stop();
      t_slave_addr();
      t_overflow();
      t_transmit();
      t_master();
      finished = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule